// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

The block gathers eight interrupt request lines into a single interrupt output for a processor. Each request line is synchronised and then captured as a pending request. Each line can be captured on its rising edge or on its level, and a mask bit can block it. Priority is fixed, with line 0 the most urgent. A request is also blocked while a request of equal or higher priority is in service. The processor acknowledges with two pulses on the acknowledge strobe. The first pulse moves the winning request into service. During the second pulse a vector byte goes onto the data bus. The vector is a programmed base in the upper five bits and the line number in the lower three.

A host port with chip select, write strobe, read strobe and one address bit is used to program the controller and to read back its pending, in-service and mask registers. Acknowledge cycles do not need chip select. Several controllers can share a private three-line cascade bus. The master drives the number of the acknowledged line on the bus, and a slave answers with its vector only when that number matches its own identity. The role comes from an input pin. In buffered mode the role is a programmed bit, and the controller drives a transceiver enable instead.

Top module: `intc_cascade`

## Requirements
- R1: A host write takes effect only at a clock where `cs_n` and `wr_n` are both low and `wr_n` was high on the previous clock. With `a0`=1 the byte goes to the register chosen by the write target: 0 or 3 selects mask, 1 selects trigger mode, 2 selects cascade. With `a0`=0 the byte is a command. If bit 7 is 0 it is a base word: bits 4:0 are the vector base, bit 6 turns buffered mode on, and bit 5 is the buffered-mode role (1 for master). Bits 7:5 = 100 is end-of-interrupt. Bits 7:5 = 101 is a select word: bit 3 is the read select (1 reads in-service) and bits 1:0 are the write target. Bits 7:5 = 11x are ignored. Writes with `cs_n` high are ignored.
- R2: While `cs_n` and `rd_n` are low, `dout_oe` is 1. With `a0`=1, `dout` shows the mask. With `a0`=0 it shows the pending register, or the in-service register if the read select is 1. Outside reads and vector cycles, `dout_oe` is 0 and `dout` is 0.
- R3: Each request line passes through two synchronising flops. In edge mode (trigger bit 0), a low-to-high change on the line sets its pending bit three clocks after the change is sampled. The bit clears when the line goes low or when the request is acknowledged. A line held high after its acknowledge does not request again.
- R4: In level mode (trigger bit 1), the pending bit follows the line level with a three-clock delay.
- R5: `irq_out` is 1 exactly when some pending bit has its mask bit at 0 and a lower index than every in-service bit.
- R6: Acknowledge needs no chip select. On the first falling edge of `inta_n`, the lowest-index qualifying request is set in service, and in edge mode its pending bit is cleared. After the second falling edge, on each clock while `inta_n` stays low, the controller drives `dout` = base*8 + line. If nothing qualified at the first edge, the line is 7 and the in-service register is unchanged. A rise of `inta_n` after the second pulse ends the sequence.
- R7: An end-of-interrupt command clears the lowest-index in-service bit.
- R8: A master drives `cas_oe`=1. It outputs the acknowledged line on `cas_out` from the first acknowledge edge until the sequence ends, and 0 otherwise. A master does not drive the vector if the cascade register bit for that line is 1.
- R9: A slave holds `cas_oe`=0 and `cas_out`=0. In the second pulse it drives its vector only if `cas_in` equals bits 2:0 of its cascade register.
- R10: With buffered mode off, the role is master when `ms_sel_in` is 1 and `xcvr_en` is 0. With buffered mode on, the programmed role bit sets the role and `xcvr_en` equals `dout_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe, active low |
| rd_n | input | 1 | Host read strobe, active low |
| a0 | input | 1 | Register/command select |
| din | input | 8 | Host write data |
| dout | output | 8 | Read data or vector |
| dout_oe | output | 1 | Data bus drive enable |
| inta_n | input | 1 | Interrupt acknowledge strobe, active low |
| irq_in | input | 8 | Request lines, line 0 most urgent |
| irq_out | output | 1 | Interrupt to the processor |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_oe | output | 1 | Cascade bus drive enable |
| ms_sel_in | input | 1 | Role select when unbuffered (1 master) |
| xcvr_en | output | 1 | Transceiver enable in buffered mode |

## Verification
A change on a request line shows on the pending register and on `irq_out` three rising edges after it is sampled. A register write or command acts at the rising edge that sees the first low clock of `wr_n`. The vector shows on the first falling-edge sample after the rising edge that registers the second low on `inta_n`. Reads and role changes are combinational and show in the same cycle. The bench drives inputs just after a falling edge, steps a behavioural model at each rising edge, and compares all outputs at the next falling edge. It also checks the literal values expected at each of these points.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    localparam int IRQ_N  = 8;
    localparam int IDX_W  = $clog2(IRQ_N);
    localparam int DATA_W = 8;
    localparam int BASE_W = DATA_W - IDX_W;

    // command byte fields (a0 = 0)
    localparam int CMD_TOP      = DATA_W - 1;
    localparam int BIT_BUF_ON   = 6;
    localparam int BIT_BUF_MSTR = 5;
    localparam int BIT_RD_ISR   = 3;

    typedef enum logic [1:0] {
        TGT_MASK     = 2'd0,
        TGT_TRIG     = 2'd1,
        TGT_CASC     = 2'd2,
        TGT_MASK_ALT = 2'd3
    } wr_target_e;

    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_ARMED  = 2'd1,
        ACK_VECTOR = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              buf_on;
        logic              buf_master;
        logic              rd_isr;
        wr_target_e        tgt;
    } host_cfg_t;

    // isolate the lowest set bit
    function automatic logic [IRQ_N-1:0] lowest_bit(input logic [IRQ_N-1:0] v);
        return v & (~v + IRQ_N'(1));
    endfunction

    // index of lowest set bit; last index when empty
    function automatic logic [IDX_W-1:0] first_index(input logic [IRQ_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = IDX_W'(IRQ_N - 1);
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // lines strictly more urgent than every in-service line
    function automatic logic [IRQ_N-1:0] above_service(input logic [IRQ_N-1:0] isr);
        logic [IRQ_N-1:0] r;
        logic             blk;
        blk = 1'b0;
        for (int i = 0; i < IRQ_N; i++) begin
            blk  = blk | isr[i];
            r[i] = ~blk;
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_req_capture.sv
`timescale 1ns/1ps
module intc_req_capture #(
    parameter int N_IRQ       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] level_mode,
    input  logic [N_IRQ-1:0] ack_clr,
    output logic [N_IRQ-1:0] irr
);

    logic [SYNC_STAGES-1:0][N_IRQ-1:0] chain;
    logic [N_IRQ-1:0]                  synced;
    logic [N_IRQ-1:0]                  prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= irq_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
            prev <= synced;
        end
    end

    assign synced = chain[SYNC_STAGES-1];

    for (genvar b = 0; b < N_IRQ; b++) begin : g_line
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q <= 1'b0;
            end else if (level_mode[b]) begin
                req_q <= synced[b];
            end else begin
                // armed by a rising edge, withdrawn by a low line or an acknowledge
                req_q <= synced[b] & (req_q | ~prev[b]) & ~ack_clr[b];
            end
        end
        assign irr[b] = req_q;
    end

endmodule

// File: rtl/intc_host_if.sv
`timescale 1ns/1ps
module intc_host_if
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    input  logic [IRQ_N-1:0]  irr,
    input  logic [IRQ_N-1:0]  isr,
    output logic [IRQ_N-1:0]  mask,
    output logic [IRQ_N-1:0]  trig_level,
    output logic [IRQ_N-1:0]  casc,
    output host_cfg_t         cfg,
    output logic              eoi,
    output logic              rd_act,
    output logic [DATA_W-1:0] rd_data
);

    logic wr_q;
    logic wr_go;
    logic is_base;
    logic is_eoi;
    logic is_sel;

    assign wr_go   = ~cs_n & ~wr_n & wr_q;
    assign is_base = ~a0 & ~din[CMD_TOP];
    assign is_eoi  = ~a0 & (din[CMD_TOP -: 3] == 3'b100);
    assign is_sel  = ~a0 & (din[CMD_TOP -: 3] == 3'b101);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q       <= 1'b1;
            mask       <= '0;
            trig_level <= '0;
            casc       <= '0;
            cfg        <= '{base: '0, buf_on: 1'b0, buf_master: 1'b0,
                            rd_isr: 1'b0, tgt: TGT_MASK};
        end else begin
            wr_q <= wr_n;
            if (wr_go) begin
                if (a0) begin
                    case (cfg.tgt)
                        TGT_TRIG: trig_level <= din;
                        TGT_CASC: casc       <= din;
                        default:  mask       <= din;
                    endcase
                end else if (is_base) begin
                    cfg.base       <= din[BASE_W-1:0];
                    cfg.buf_on     <= din[BIT_BUF_ON];
                    cfg.buf_master <= din[BIT_BUF_MSTR];
                end else if (is_sel) begin
                    cfg.rd_isr <= din[BIT_RD_ISR];
                    cfg.tgt    <= wr_target_e'(din[1:0]);
                end
            end
        end
    end

    assign eoi     = wr_go & is_eoi;
    assign rd_act  = ~cs_n & ~rd_n;
    assign rd_data = a0 ? mask : (cfg.rd_isr ? isr : irr);

endmodule

// File: rtl/intc_ack_seq.sv
`timescale 1ns/1ps
module intc_ack_seq
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inta_n,
    input  logic [IRQ_N-1:0]  pending,
    input  logic              is_master,
    input  logic [IRQ_N-1:0]  casc,
    input  logic [BASE_W-1:0] base,
    input  logic [IDX_W-1:0]  cas_in,
    input  logic              eoi,
    output logic [IRQ_N-1:0]  isr,
    output logic [IRQ_N-1:0]  ack_clr,
    output logic [IDX_W-1:0]  cas_out,
    output logic              vec_drive,
    output logic [DATA_W-1:0] vec
);

    ack_state_e       st;
    logic             inta_q;
    logic [IDX_W-1:0] sel_idx;
    logic             fall;
    logic             rise;
    logic             commit;
    logic [IRQ_N-1:0] eoi_clr;
    logic             selected;

    assign fall    = inta_q & ~inta_n;
    assign rise    = ~inta_q & inta_n;
    assign commit  = (st == ACK_IDLE) & fall;
    assign ack_clr = commit ? lowest_bit(pending) : '0;
    assign eoi_clr = eoi ? lowest_bit(isr) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ACK_IDLE;
            inta_q  <= 1'b1;
            isr     <= '0;
            sel_idx <= '0;
        end else begin
            inta_q <= inta_n;
            isr    <= (isr & ~eoi_clr) | ack_clr;
            case (st)
                ACK_IDLE: if (fall) begin
                    st      <= ACK_ARMED;
                    sel_idx <= first_index(pending);
                end
                ACK_ARMED:  if (fall) st <= ACK_VECTOR;
                ACK_VECTOR: if (rise) st <= ACK_IDLE;
                default:    st <= ACK_IDLE;
            endcase
        end
    end

    assign selected  = is_master ? ~casc[sel_idx] : (cas_in == casc[IDX_W-1:0]);
    assign vec_drive = (st == ACK_VECTOR) & ~inta_n & selected;
    assign vec       = {base, sel_idx};
    assign cas_out   = (is_master && st != ACK_IDLE) ? sel_idx : '0;

endmodule

// File: rtl/intc_cascade.sv
`timescale 1ns/1ps
module intc_cascade
    import intc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    input  logic              inta_n,
    input  logic [IRQ_N-1:0]  irq_in,
    output logic              irq_out,
    input  logic [IDX_W-1:0]  cas_in,
    output logic [IDX_W-1:0]  cas_out,
    output logic              cas_oe,
    input  logic              ms_sel_in,
    output logic              xcvr_en
);

    logic [IRQ_N-1:0]  irr;
    logic [IRQ_N-1:0]  isr;
    logic [IRQ_N-1:0]  mask;
    logic [IRQ_N-1:0]  trig_level;
    logic [IRQ_N-1:0]  casc;
    logic [IRQ_N-1:0]  ack_clr;
    logic [IRQ_N-1:0]  pending;
    host_cfg_t         cfg;
    logic              eoi;
    logic              rd_act;
    logic [DATA_W-1:0] rd_data;
    logic              is_master;
    logic              vec_drive;
    logic [DATA_W-1:0] vec;

    intc_req_capture #(
        .N_IRQ       (IRQ_N),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .level_mode (trig_level),
        .ack_clr    (ack_clr),
        .irr        (irr)
    );

    intc_host_if u_host (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .wr_n       (wr_n),
        .rd_n       (rd_n),
        .a0         (a0),
        .din        (din),
        .irr        (irr),
        .isr        (isr),
        .mask       (mask),
        .trig_level (trig_level),
        .casc       (casc),
        .cfg        (cfg),
        .eoi        (eoi),
        .rd_act     (rd_act),
        .rd_data    (rd_data)
    );

    assign is_master = cfg.buf_on ? cfg.buf_master : ms_sel_in;
    assign pending   = irr & ~mask & above_service(isr);

    intc_ack_seq u_ack (
        .clk       (clk),
        .rst       (rst),
        .inta_n    (inta_n),
        .pending   (pending),
        .is_master (is_master),
        .casc      (casc),
        .base      (cfg.base),
        .cas_in    (cas_in),
        .eoi       (eoi),
        .isr       (isr),
        .ack_clr   (ack_clr),
        .cas_out   (cas_out),
        .vec_drive (vec_drive),
        .vec       (vec)
    );

    assign irq_out = |pending;
    assign dout_oe = vec_drive | rd_act;
    assign dout    = vec_drive ? vec : (rd_act ? rd_data : '0);
    assign cas_oe  = is_master;
    assign xcvr_en = cfg.buf_on & dout_oe;

endmodule

// File: rtl/intc_cascade_chk.sv
`timescale 1ns/1ps
module intc_cascade_chk
    import intc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_out,
    input logic [IRQ_N-1:0] irr,
    input logic [IRQ_N-1:0] mask,
    input logic [IRQ_N-1:0] isr,
    input logic             dout_oe,
    input logic             cs_n,
    input logic             rd_n,
    input logic             inta_n,
    input logic             xcvr_en
);

    assert_irq_needs_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((irr & ~mask) != '0));

    assert_one_grant_per_edge_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(isr & ~$past(isr)) <= 1));

    assert_bus_drive_needs_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && (cs_n || rd_n)) |-> !inta_n);

    assert_eoi_single_clear_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones($past(isr) & ~isr) <= 1));

    assert_xcvr_tracks_drive_R10: assert property (@(posedge clk) disable iff (rst)
        xcvr_en |-> dout_oe);

endmodule

bind intc_cascade intc_cascade_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_out (irq_out),
    .irr     (irr),
    .mask    (mask),
    .isr     (isr),
    .dout_oe (dout_oe),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .inta_n  (inta_n),
    .xcvr_en (xcvr_en)
);

// File: tb/intc_cascade_bench.sv
`timescale 1ns/1ps
module intc_cascade_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = 8'h00;
    logic       inta_n = 1'b1;
    logic [7:0] irq = 8'h00;
    logic [2:0] cas_in = 3'd0;
    logic       ms_sel = 1'b1;

    logic [7:0] dout;
    logic       dout_oe, irq_out, cas_oe, xcvr_en;
    logic [2:0] cas_out;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    intc_cascade u_intc_cascade (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .a0(a0),
        .din(din), .dout(dout), .dout_oe(dout_oe), .inta_n(inta_n),
        .irq_in(irq), .irq_out(irq_out), .cas_in(cas_in), .cas_out(cas_out),
        .cas_oe(cas_oe), .ms_sel_in(ms_sel), .xcvr_en(xcvr_en)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] q[$];
    logic [7:0] m_irr, m_isr, m_mask, m_trig, m_casc;
    int         m_base, m_tgt, m_st, m_sel;
    bit         m_buf, m_bufm, m_rdsel, m_wrq, m_intaq;

    function automatic int low_idx(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 7;
    endfunction

    function automatic logic [7:0] m_pending();
        int top = 8;
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) if (m_isr[i]) top = i;
        for (int i = 0; i < 8; i++)
            if (i < top && m_irr[i] && !m_mask[i]) r[i] = 1'b1;
        return r;
    endfunction

    task automatic model_reset();
        q = '{8'h00, 8'h00, 8'h00};
        m_irr = 0; m_isr = 0; m_mask = 0; m_trig = 0; m_casc = 0;
        m_base = 0; m_tgt = 0; m_st = 0; m_sel = 0;
        m_buf = 0; m_bufm = 0; m_rdsel = 0; m_wrq = 1; m_intaq = 1;
    endtask

    task automatic model_edge();
        logic [7:0] pend, clr, nirr, nisr;
        bit go, eoi, fall, rise;
        if (rst) begin model_reset(); return; end
        pend = m_pending();
        go   = !cs_n && !wr_n && m_wrq;
        eoi  = 0;
        fall = m_intaq && !inta_n;
        rise = !m_intaq && inta_n;
        clr  = 0;
        nisr = m_isr;
        if (go) begin
            if (a0) begin
                if (m_tgt == 1) m_trig = din;
                else if (m_tgt == 2) m_casc = din;
                else m_mask = din;
            end else if (!din[7]) begin
                m_base = din[4:0]; m_buf = din[6]; m_bufm = din[5];
            end else if (din[7:5] == 3'b100) begin
                eoi = 1;
            end else if (din[7:5] == 3'b101) begin
                m_rdsel = din[3]; m_tgt = din[1:0];
            end
        end
        if (eoi && m_isr != 0) nisr[low_idx(m_isr)] = 1'b0;
        case (m_st)
            0: if (fall) begin
                m_st = 1;
                m_sel = low_idx(pend);
                if (pend != 0) begin
                    nisr[m_sel] = 1'b1;
                    clr[m_sel]  = 1'b1;
                end
            end
            1: if (fall) m_st = 2;
            default: if (rise) m_st = 0;
        endcase
        for (int b = 0; b < 8; b++) begin
            if (m_trig[b]) nirr[b] = q[1][b];
            else nirr[b] = q[1][b] && (m_irr[b] || !q[2][b]) && !clr[b];
        end
        m_irr = nirr;
        m_isr = nisr;
        q.push_front(irq);
        void'(q.pop_back());
        m_wrq = wr_n;
        m_intaq = inta_n;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit master, vd, rd;
        int e_dout;
        master = m_buf ? m_bufm : ms_sel;
        vd = (m_st == 2) && !inta_n &&
             (master ? !m_casc[m_sel] : (cas_in == m_casc[2:0]));
        rd = !cs_n && !rd_n;
        e_dout = vd ? (m_base * 8 + m_sel) :
                 rd ? (a0 ? m_mask : (m_rdsel ? m_isr : m_irr)) : 0;
        check("R5", "irq_out", irq_out, m_pending() != 0);
        check(vd ? "R6" : "R2", "dout_oe", dout_oe, vd || rd);
        check(vd ? "R6" : "R2", "dout", dout, e_dout);
        check(master ? "R8" : "R9", "cas_oe", cas_oe, master);
        check(master ? "R8" : "R9", "cas_out", cas_out, (master && m_st != 0) ? m_sel : 0);
        check("R10", "xcvr_en", xcvr_en, m_buf && (vd || rd));
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic host_wr(input logic sel, input logic [7:0] d);
        cs_n = 0; a0 = sel; din = d; wr_n = 0;
        cyc(1);
        wr_n = 1; cs_n = 1;
        cyc(1);
    endtask

    task automatic host_rd(input logic sel, input logic [7:0] exp, input string req);
        cs_n = 0; rd_n = 0; a0 = sel;
        cyc(1);
        check(req, "read data", dout, exp);
        rd_n = 1; cs_n = 1;
        cyc(1);
    endtask

    task automatic do_ack(input bit exp_oe, input logic [7:0] exp_vec,
                          input int exp_cas, input string req);
        inta_n = 0; cyc(1);
        check(req, "cascade code", cas_out, exp_cas);
        inta_n = 1; cyc(1);
        inta_n = 0; cyc(1);
        check(req, "vector drive", dout_oe, exp_oe);
        if (exp_oe) check(req, "vector", dout, exp_vec);
        cyc(1);
        inta_n = 1; cyc(1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        cyc(3);
        rst = 0;
        cyc(1);
        check("R2", "reset dout_oe", dout_oe, 0);
        check("R5", "reset irq_out", irq_out, 0);
        check("R10", "reset role", cas_oe, 1);

        // R3: edge request, three-clock latency
        host_wr(0, 8'h0A);
        irq[3] = 1;
        cyc(2); check("R3", "irq before latency", irq_out, 0);
        cyc(1); check("R3", "irq after latency", irq_out, 1);
        host_rd(0, 8'h08, "R2");
        do_ack(1, 8'h53, 3, "R6");
        check("R5", "irq in service", irq_out, 0);
        host_wr(0, 8'hA8);
        host_rd(0, 8'h08, "R7");
        host_wr(0, 8'h80);
        host_rd(0, 8'h00, "R7");
        check("R3", "held line no rerequest", irq_out, 0);
        irq[3] = 0; cyc(3);
        irq[3] = 1; cyc(3);
        check("R3", "rearmed", irq_out, 1);
        irq[3] = 0; cyc(3);
        check("R3", "withdrawn", irq_out, 0);

        // R4: level line 5 with edge line 1
        host_wr(0, 8'hA1); host_wr(1, 8'h20); host_wr(0, 8'hA8);
        irq[5] = 1; irq[1] = 1;
        cyc(3); check("R4", "level pending", irq_out, 1);
        do_ack(1, 8'h51, 1, "R6");
        check("R5", "nested block", irq_out, 0);
        host_wr(0, 8'h80);
        check("R4", "level still high", irq_out, 1);
        do_ack(1, 8'h55, 5, "R6");
        host_rd(0, 8'h20, "R7");
        irq[5] = 0; irq[1] = 0; cyc(3);
        host_wr(0, 8'h80);
        host_rd(0, 8'h00, "R7");

        // R5: mask
        host_wr(1, 8'h01);
        irq[0] = 1; cyc(4);
        check("R5", "masked", irq_out, 0);
        host_wr(1, 8'h00);
        check("R5", "unmasked", irq_out, 1);
        do_ack(1, 8'h50, 0, "R6");
        host_wr(0, 8'h80);
        irq[0] = 0; cyc(3);

        // R6: nothing pending
        do_ack(1, 8'h57, 7, "R6");
        host_rd(0, 8'h00, "R6");

        // R8: master, line 2 has a slave
        host_wr(0, 8'hA2); host_wr(1, 8'h04); host_wr(0, 8'hA8);
        irq[2] = 1; cyc(3);
        do_ack(0, 8'h00, 2, "R8");
        host_wr(0, 8'h80);
        irq[2] = 0; cyc(3);

        // R1: ignored writes
        cs_n = 1; a0 = 1; din = 8'hFF; wr_n = 0; cyc(1);
        wr_n = 1; cyc(1);
        host_rd(1, 8'h00, "R1");
        host_wr(0, 8'hE5);
        host_wr(1, 8'h03);
        host_rd(1, 8'h03, "R1");
        host_wr(1, 8'h00);

        // R9: slave with identity 4
        ms_sel = 0; cyc(1);
        check("R9", "slave cas_oe", cas_oe, 0);
        irq[6] = 1; cyc(3);
        cas_in = 3'd4;
        do_ack(1, 8'h56, 0, "R9");
        host_wr(0, 8'h80);
        irq[6] = 0; cyc(3);
        irq[6] = 1; cyc(3);
        cas_in = 3'd1;
        do_ack(0, 8'h00, 0, "R9");
        host_wr(0, 8'h80);
        irq[6] = 0; cyc(3);

        // R10: buffered mode
        host_wr(0, 8'h6A);
        check("R10", "buffered master", cas_oe, 1);
        cs_n = 0; rd_n = 0; a0 = 1; cyc(1);
        check("R10", "xcvr on read", xcvr_en, 1);
        rd_n = 1; cs_n = 1; cyc(1);
        check("R10", "xcvr idle", xcvr_en, 0);
        host_wr(0, 8'h4A);
        check("R10", "buffered slave", cas_oe, 0);
        host_wr(0, 8'h0A);
        ms_sel = 1; cyc(2);

        done = 1;
        summary();
        $finish;
    end

endmodule